// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block follows a chain of 16-byte scatter-gather entries held in memory. Software gives it the address of the first entry and a start strobe. The block reads the entry as four 32-bit words and turns it into one transfer request for a downstream data mover. That request carries the buffer address, the byte count, the direction, the ordering hint and a 4-bit transfer mode. Once the mover accepts the request, the walker reads the entry named by that entry's link word. The walk ends at the entry that carries the terminal flag, and a one-cycle completion pulse reports the end.

Lengths are stored in units of eight bytes and are widened to bytes on the way out. The walker never lets a fetch overlap a pending request, so the memory port and the mover port are never busy at the same time. A broken link stops the walk with a one-cycle fault pulse instead of a completion pulse. A broken link is a zero link in a non-terminal entry, or a link that is not 8-byte aligned. A start pointer that is not 8-byte aligned is refused in the same way.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `mem_req` and `xfer_valid` are all low.
- R2: A start with an 8-byte-aligned pointer P reads the four words at P, P+4, P+8 and P+12 in that order. Each read holds `mem_req` and a stable `mem_addr` until the cycle in which `mem_ack` is high, and `mem_rdata` is taken in that cycle.
- R3: `xfer_addr` equals word 0 of the entry. `xfer_len` equals word 1 multiplied by 8, carried in 35 bits so that no bit is lost.
- R4: The flag byte is bits 7:0 of word 2. In that byte, bit 4 drives `xfer_ordered` and bit 5 drives `xfer_write`. `xfer_mode` is bits 11:8 of word 2. All other bits of word 2 have no effect on the outputs.
- R5: `xfer_valid` stays high with all request fields stable until `xfer_ready` is seen. No memory read is issued while a request is pending.
- R6: After a non-terminal entry's request is accepted, the next entry is read from the pointer in word 3. The walk follows that pointer even when entries are not laid out contiguously.
- R7: When the request of an entry whose flag bit 7 is set is accepted, `done` is high for exactly the following cycle and `busy` falls. That entry's word 3 is ignored.
- R8: If a non-terminal entry's word 3 is zero or has any of bits 2:0 set, accepting its request raises `error` for exactly one cycle. In that case no further read is made and `done` stays low.
- R9: A start whose pointer has any of bits 2:0 set raises `error` in the next cycle and issues no read and no request.
- R10: A start strobe that arrives while `busy` is high has no effect on the walk in progress.
- R11: A start strobe that arrives in the cycle in which `done` is high begins a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at `start_ptr` (honoured only when idle) |
| start_ptr | input | 32 | Byte address of the first entry |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: terminal entry accepted |
| error | output | 1 | One-cycle pulse: bad start pointer or broken link |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read completes; `mem_rdata` valid |
| mem_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_addr | output | 32 | Buffer byte address |
| xfer_len | output | 35 | Transfer length in bytes |
| xfer_write | output | 1 | Transfer goes out to the device |
| xfer_ordered | output | 1 | Ordering hint |
| xfer_mode | output | 4 | Transfer mode |

## Verification
Two functions can fall in the same cycle. The first is the completion pulse of one walk. The second is the acceptance of a new start, because the walker is already idle while `done` is high. The bench provokes this by watching for `done` and raising `start` with a second chain's pointer within that same cycle. It then judges that the transfer log holds both chains back to back and that exactly two completion pulses were counted. A second meeting point is a start strobe during a running walk. That strobe must not disturb the walk, and the bench checks this from the fetch and transfer logs alone.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  // entry layout: four little-endian words
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 4;
  localparam int MODE_W      = 4;

  // word indices inside one entry
  localparam int WI_BUF  = 0;
  localparam int WI_LEN  = 1;
  localparam int WI_CTRL = 2;
  localparam int WI_LINK = 3;

  // bit positions inside the flag byte (low byte of the control word)
  localparam int FB_ORDERED = 4;
  localparam int FB_OUTWARD = 5;
  localparam int FB_TERMINAL = 7;
  localparam int MODE_LSB   = 8;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_FETCH = 2'd1,
    WALK_OFFER = 2'd2
  } walk_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] buf_addr;
    logic [WORD_W-1:0] len_units;
    logic              ordered;
    logic              outward;
    logic              terminal;
    logic [MODE_W-1:0] mode;
    logic [WORD_W-1:0] link;
  } entry_t;

  function automatic logic ptr_aligned(input logic [WORD_W-1:0] p, input int align_bits);
    logic [WORD_W-1:0] mask;
    mask = (WORD_W'(1) << align_bits) - WORD_W'(1);
    return (p & mask) == '0;
  endfunction
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go,
  input  logic [WORD_W-1:0]             base,
  output logic                          mem_req,
  output logic [WORD_W-1:0]             mem_addr,
  input  logic                          mem_ack,
  input  logic [WORD_W-1:0]             mem_rdata,
  output logic [ENTRY_WORDS*WORD_W-1:0] entry_words,
  output logic                          fetched
);
  localparam int CNT_W   = $clog2(ENTRY_WORDS);
  localparam int BYTE_SH = $clog2(WORD_W / 8);

  logic              active_q;
  logic [CNT_W-1:0]  beat_q;
  logic [WORD_W-1:0] base_q;
  logic [WORD_W-1:0] words_q [ENTRY_WORDS];
  logic              last_beat;

  function automatic logic [WORD_W-1:0] beat_offset(input logic [CNT_W-1:0] b);
    return WORD_W'(b) << BYTE_SH;
  endfunction

  assign mem_req   = active_q;
  assign mem_addr  = base_q + beat_offset(beat_q);
  assign last_beat = (beat_q == CNT_W'(ENTRY_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      fetched  <= 1'b0;
      for (int i = 0; i < ENTRY_WORDS; i++) words_q[i] <= '0;
    end else begin
      fetched <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        base_q   <= base;
      end else if (active_q && mem_ack) begin
        words_q[beat_q] <= mem_rdata;
        if (last_beat) begin
          active_q <= 1'b0;
          fetched  <= 1'b1;
        end else begin
          beat_q <= beat_q + CNT_W'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRY_WORDS; g++) begin : g_flat
    assign entry_words[g*WORD_W +: WORD_W] = words_q[g];
  end
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
#(
  parameter int LEN_SHIFT = 3
)(
  input  logic [ENTRY_WORDS*WORD_W-1:0]  entry_words,
  output entry_t                         ent,
  output logic [WORD_W+LEN_SHIFT-1:0]    byte_len
);
  localparam int LEN_W = WORD_W + LEN_SHIFT;

  logic [WORD_W-1:0] w_buf, w_len, w_ctrl, w_link;
  logic              ctrl_unused;

  function automatic logic [LEN_W-1:0] units_to_bytes(input logic [WORD_W-1:0] u);
    return LEN_W'(u) << LEN_SHIFT;
  endfunction

  assign w_buf  = entry_words[WI_BUF*WORD_W  +: WORD_W];
  assign w_len  = entry_words[WI_LEN*WORD_W  +: WORD_W];
  assign w_ctrl = entry_words[WI_CTRL*WORD_W +: WORD_W];
  assign w_link = entry_words[WI_LINK*WORD_W +: WORD_W];

  assign ent.buf_addr  = w_buf;
  assign ent.len_units = w_len;
  assign ent.ordered   = w_ctrl[FB_ORDERED];
  assign ent.outward   = w_ctrl[FB_OUTWARD];
  assign ent.terminal  = w_ctrl[FB_TERMINAL];
  assign ent.mode      = w_ctrl[MODE_LSB +: MODE_W];
  assign ent.link      = w_link;
  assign byte_len      = units_to_bytes(w_len);

  // reserved and packet-length bytes carry no meaning here
  assign ctrl_unused = ^{w_ctrl[WORD_W-1:MODE_LSB+MODE_W], w_ctrl[6], w_ctrl[3:0]};
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
#(
  parameter int ALIGN_BITS = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_ptr,
  input  logic              fetched,
  input  logic              ent_terminal,
  input  logic [WORD_W-1:0] ent_link,
  input  logic              xfer_ready,
  output logic              fetch_go,
  output logic [WORD_W-1:0] fetch_base,
  output logic              xfer_valid,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              error
);
  walk_state_e st_q, st_d;
  logic        done_d, err_d;
  logic        start_ok, link_ok;

  assign start_ok   = ptr_aligned(start_ptr, ALIGN_BITS);
  assign link_ok    = (ent_link != '0) && ptr_aligned(ent_link, ALIGN_BITS);
  assign xfer_valid = (st_q == WALK_OFFER);
  assign accept     = xfer_valid && xfer_ready;
  assign busy       = (st_q != WALK_IDLE);

  always_comb begin
    st_d       = st_q;
    fetch_go   = 1'b0;
    fetch_base = start_ptr;
    done_d     = 1'b0;
    err_d      = 1'b0;
    case (st_q)
      WALK_IDLE: begin
        if (start) begin
          if (start_ok) begin
            fetch_go = 1'b1;
            st_d     = WALK_FETCH;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      WALK_FETCH: begin
        if (fetched) st_d = WALK_OFFER;
      end
      WALK_OFFER: begin
        if (xfer_ready) begin
          if (ent_terminal) begin
            done_d = 1'b1;
            st_d   = WALK_IDLE;
          end else if (link_ok) begin
            fetch_go   = 1'b1;
            fetch_base = ent_link;
            st_d       = WALK_FETCH;
          end else begin
            err_d = 1'b1;
            st_d  = WALK_IDLE;
          end
        end
      end
      default: st_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WALK_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      st_q  <= st_d;
      done  <= done_d;
      error <= err_d;
    end
  end
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int LEN_SHIFT  = 3,
  parameter int ALIGN_BITS = 3
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [WORD_W-1:0]           start_ptr,
  output logic                        busy,
  output logic                        done,
  output logic                        error,
  output logic                        mem_req,
  output logic [WORD_W-1:0]           mem_addr,
  input  logic                        mem_ack,
  input  logic [WORD_W-1:0]           mem_rdata,
  output logic                        xfer_valid,
  input  logic                        xfer_ready,
  output logic [WORD_W-1:0]           xfer_addr,
  output logic [WORD_W+LEN_SHIFT-1:0] xfer_len,
  output logic                        xfer_write,
  output logic                        xfer_ordered,
  output logic [MODE_W-1:0]           xfer_mode
);
  logic                          ev_fetch_go;
  logic                          ev_accept;
  logic                          ev_fetched;
  logic [WORD_W-1:0]             fetch_base;
  logic [ENTRY_WORDS*WORD_W-1:0] entry_words;
  entry_t                        ent;
  logic                          ent_unused;

  sgw_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (ev_fetch_go),
    .base        (fetch_base),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .entry_words (entry_words),
    .fetched     (ev_fetched)
  );

  sgw_decode #(.LEN_SHIFT(LEN_SHIFT)) u_decode (
    .entry_words (entry_words),
    .ent         (ent),
    .byte_len    (xfer_len)
  );

  sgw_ctrl #(.ALIGN_BITS(ALIGN_BITS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_ptr    (start_ptr),
    .fetched      (ev_fetched),
    .ent_terminal (ent.terminal),
    .ent_link     (ent.link),
    .xfer_ready   (xfer_ready),
    .fetch_go     (ev_fetch_go),
    .fetch_base   (fetch_base),
    .xfer_valid   (xfer_valid),
    .accept       (ev_accept),
    .busy         (busy),
    .done         (done),
    .error        (error)
  );

  assign xfer_addr    = ent.buf_addr;
  assign xfer_write   = ent.outward;
  assign xfer_ordered = ent.ordered;
  assign xfer_mode    = ent.mode;
  assign ent_unused   = ^ent.len_units;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
#(
  parameter int LEN_SHIFT = 3
)(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy,
  input logic                        done,
  input logic                        error,
  input logic                        mem_req,
  input logic [WORD_W-1:0]           mem_addr,
  input logic                        mem_ack,
  input logic                        xfer_valid,
  input logic                        xfer_ready,
  input logic [WORD_W-1:0]           xfer_addr,
  input logic [WORD_W+LEN_SHIFT-1:0] xfer_len,
  input logic                        xfer_write,
  input logic                        xfer_ordered,
  input logic [MODE_W-1:0]           xfer_mode,
  input logic                        ev_accept,
  input logic                        ev_fetch_go
);
  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !xfer_valid);

  p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_offer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len)
      && $stable(xfer_write) && $stable(xfer_ordered) && $stable(xfer_mode));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !mem_req);

  p_go_from_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_go |-> !mem_req);

  p_done_follows_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ev_accept));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_single_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error}));

  p_error_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !mem_req && !xfer_valid);
endmodule

bind sg_chain_walker sgw_checker #(.LEN_SHIFT(LEN_SHIFT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .error        (error),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .xfer_valid   (xfer_valid),
  .xfer_ready   (xfer_ready),
  .xfer_addr    (xfer_addr),
  .xfer_len     (xfer_len),
  .xfer_write   (xfer_write),
  .xfer_ordered (xfer_ordered),
  .xfer_mode    (xfer_mode),
  .ev_accept    (ev_accept),
  .ev_fetch_go  (ev_fetch_go)
);

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        busy, done, error;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        xfer_valid, xfer_ready;
  logic [31:0] xfer_addr;
  logic [34:0] xfer_len;
  logic        xfer_write, xfer_ordered;
  logic [3:0]  xfer_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .busy(busy), .done(done), .error(error),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_write(xfer_write), .xfer_ordered(xfer_ordered),
    .xfer_mode(xfer_mode)
  );

  // memory and mover stubs
  logic [31:0] mem [0:255];
  int mem_lat = 0, rdy_lat = 0, mcnt = 0, vcnt = 0;
  assign mem_rdata  = mem[mem_addr[9:2]];
  assign mem_ack    = mem_req && (mcnt >= mem_lat);
  assign xfer_ready = xfer_valid && (vcnt >= rdy_lat);

  // logs
  logic [31:0] flog [0:63];
  logic [31:0] xa [0:31];
  logic [34:0] xl [0:31];
  logic        xw [0:31];
  logic        xo [0:31];
  logic [3:0]  xm [0:31];
  int fn = 0, xn = 0, dn = 0, en = 0, overlap = 0;

  always @(posedge clk) begin
    mcnt <= (mem_req && !mem_ack) ? mcnt + 1 : 0;
    vcnt <= (xfer_valid && !xfer_ready) ? vcnt + 1 : 0;
    if (rst_n) begin
      if (mem_req && mem_ack && fn < 64) begin flog[fn] = mem_addr; fn = fn + 1; end
      if (xfer_valid && xfer_ready && xn < 32) begin
        xa[xn] = xfer_addr; xl[xn] = xfer_len; xw[xn] = xfer_write;
        xo[xn] = xfer_ordered; xm[xn] = xfer_mode; xn = xn + 1;
      end
      if (mem_req && xfer_valid) overlap = overlap + 1;
      if (done) dn = dn + 1;
      if (error) en = en + 1;
    end
  end

  // expected entries
  logic [31:0] eptr [0:31];
  logic [31:0] ea [0:31];
  logic [34:0] el [0:31];
  logic        ew [0:31];
  logic        eo [0:31];
  logic [3:0]  em [0:31];
  int ecnt = 0;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    fn = 0; xn = 0; dn = 0; en = 0; ecnt = 0; overlap = 0;
  endtask

  // ctrl word carries junk in every bit the walker must ignore (R4)
  task automatic put_entry(input logic [31:0] ptr, input logic [31:0] a, input logic [31:0] u,
                           input logic wr, input logic ord, input logic last,
                           input logic [3:0] md, input logic [31:0] nxt, input bit expect_it);
    mem[ptr[9:2]]       = a;
    mem[ptr[9:2] + 8'd1] = u;
    mem[ptr[9:2] + 8'd2] = {8'hC3, 8'h5A, 4'h9, md, last, 1'b1, wr, ord, 4'hB};
    mem[ptr[9:2] + 8'd3] = nxt;
    if (expect_it) begin
      eptr[ecnt] = ptr; ea[ecnt] = a; el[ecnt] = 35'(u) * 35'd8;
      ew[ecnt] = wr; eo[ecnt] = ord; em[ecnt] = md; ecnt++;
    end
  endtask

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk); start = 1'b1; start_ptr = p;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_outcomes(input int target);
    for (int i = 0; i < 3000 && (dn + en) < target; i++) @(negedge clk);
  endtask

  task automatic check_logs();
    chk(fn == 4*ecnt, "R2 read count", 64'(fn), 64'(4*ecnt));
    for (int i = 0; i < fn && i < 4*ecnt; i++)
      chk(flog[i] == eptr[i/4] + 32'(4*(i%4)), "R2 R6 read address", 64'(flog[i]), 64'(eptr[i/4] + 32'(4*(i%4))));
    chk(xn == ecnt, "R6 request count", 64'(xn), 64'(ecnt));
    for (int i = 0; i < xn && i < ecnt; i++) begin
      chk(xa[i] == ea[i], "R3 address", 64'(xa[i]), 64'(ea[i]));
      chk(xl[i] == el[i], "R3 byte length", 64'(xl[i]), 64'(el[i]));
      chk({xw[i], xo[i], xm[i]} == {ew[i], eo[i], em[i]}, "R4 write/ordered/mode",
          64'({xw[i], xo[i], xm[i]}), 64'({ew[i], eo[i], em[i]}));
    end
    chk(overlap == 0, "R5 read during pending request", 64'(overlap), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    repeat (3) @(negedge clk);
    chk({busy, done, error, mem_req, xfer_valid} == 5'b0, "R1 reset outputs",
        64'({busy, done, error, mem_req, xfer_valid}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, error, mem_req, xfer_valid} == 5'b0, "R1 idle after reset",
        64'({busy, done, error, mem_req, xfer_valid}), 64'(0));

    // sweep: chain length x memory latency x mover latency, entries laid out in reverse
    for (int n = 1; n <= 4; n++)
      for (int ml = 0; ml < 3; ml++)
        for (int rl = 0; rl < 3; rl++) begin
          logic [31:0] base;
          clear_logs();
          mem_lat = ml; rdy_lat = rl;
          base = 32'h40 + 32'(8*((ml + rl) % 3));
          for (int k = 0; k < n; k++) begin
            logic [31:0] p, nx, u;
            p  = base + 32'(24*(n-1-k));
            nx = (k == n-1) ? ((rl % 2 == 1) ? 32'h1234_5671 : 32'h0) : base + 32'(24*(n-2-k));
            u  = (k == 0 && ml == 2 && rl == 2) ? 32'hFFFF_FFFF : 32'(k*1000 + n*7 + ml + 1);
            put_entry(p, 32'h8000_0000 ^ (32'(k)*32'h0101_0100 + 32'(n*16 + ml*4 + rl)), u,
                      1'((k + ml) % 2), 1'((k + rl) % 2), k == n-1, 4'((k*5 + n + ml) % 16), nx, 1'b1);
          end
          pulse_start(base + 32'(24*(n-1)));
          wait_outcomes(1);
          @(negedge clk);
          check_logs();
          chk(dn == 1 && en == 0, "R7 completion pulse", 64'({dn, en}), 64'({32'd1, 32'd0}));
          chk(!busy, "R7 busy drops", 64'(busy), 64'(0));
        end

    // R8: zero link in a non-terminal entry
    clear_logs(); mem_lat = 1; rdy_lat = 1;
    put_entry(32'h100, 32'hA000_0000, 32'd5, 1'b1, 1'b0, 1'b0, 4'h3, 32'h0, 1'b1);
    pulse_start(32'h100);
    wait_outcomes(1);
    repeat (20) @(negedge clk);
    check_logs();
    chk(en == 1 && dn == 0, "R8 zero link faults", 64'({en, dn}), 64'({32'd1, 32'd0}));

    // R8: misaligned link
    clear_logs();
    put_entry(32'h108, 32'hA000_1000, 32'd9, 1'b0, 1'b1, 1'b0, 4'hC, 32'h0000_0124, 1'b1);
    put_entry(32'h120, 32'hA000_2000, 32'd9, 1'b0, 1'b1, 1'b1, 4'hC, 32'h0, 1'b0);
    pulse_start(32'h108);
    wait_outcomes(1);
    repeat (20) @(negedge clk);
    check_logs();
    chk(en == 1 && dn == 0, "R8 misaligned link faults", 64'({en, dn}), 64'({32'd1, 32'd0}));

    // R9: misaligned start pointer
    clear_logs();
    pulse_start(32'h0000_010C);
    wait_outcomes(1);
    repeat (10) @(negedge clk);
    chk(en == 1 && dn == 0, "R9 bad start faults", 64'({en, dn}), 64'({32'd1, 32'd0}));
    chk(fn == 0 && xn == 0, "R9 no activity", 64'({fn, xn}), 64'(0));

    // R10: start during a running walk is ignored
    clear_logs(); mem_lat = 2; rdy_lat = 2;
    put_entry(32'h200, 32'hB000_0000, 32'd11, 1'b1, 1'b1, 1'b0, 4'h7, 32'h218, 1'b1);
    put_entry(32'h218, 32'hB000_0100, 32'd12, 1'b0, 1'b0, 1'b1, 4'h8, 32'h0, 1'b1);
    put_entry(32'h300, 32'hC000_0000, 32'd13, 1'b1, 1'b0, 1'b1, 4'h1, 32'h0, 1'b0);
    pulse_start(32'h200);
    repeat (2) @(negedge clk);
    pulse_start(32'h300);
    wait_outcomes(1);
    repeat (60) @(negedge clk);
    check_logs();
    chk(dn == 1 && en == 0, "R10 one completion only", 64'({dn, en}), 64'({32'd1, 32'd0}));

    // R11: start in the completion cycle begins a new walk
    clear_logs(); mem_lat = 0; rdy_lat = 0;
    put_entry(32'h200, 32'hD000_0000, 32'd21, 1'b0, 1'b1, 1'b0, 4'hA, 32'h218, 1'b1);
    put_entry(32'h218, 32'hD000_0200, 32'd22, 1'b1, 1'b1, 1'b1, 4'hB, 32'h0, 1'b1);
    put_entry(32'h300, 32'hE000_0000, 32'd23, 1'b1, 1'b0, 1'b1, 4'h2, 32'h0, 1'b1);
    pulse_start(32'h200);
    for (int i = 0; i < 500 && !done; i++) @(negedge clk);
    chk(done, "R11 completion seen", 64'(done), 64'(1));
    start = 1'b1; start_ptr = 32'h300;
    @(negedge clk); start = 1'b0;
    wait_outcomes(2);
    @(negedge clk);
    check_logs();
    chk(dn == 2 && en == 0, "R11 back-to-back walks", 64'({dn, en}), 64'({32'd2, 32'd0}));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule